// File: doc/BRIEF.md
# Flash Geometry Query Engine

This block interrogates one parallel NOR flash device through a small synchronous bus master port. A start pulse triggers a fixed sequence: a reset command and an enter-query command, three reads that must return the ASCII identification signature, a header scan for the command-set code, the two timeout exponents, the device size and the erase-region count, and then four descriptor bytes per region. The engine finishes by leaving query mode with the exit commands that suit the reported command set.

Results sit in output registers until the next accepted start. They are a done/valid/fail status, the vendor command-set code, the write and erase timeout exponents, the device size in bytes, a region count clamped to the storage provided with an overflow flag, and one start offset, block count and block size per region. A boot or update controller reads these outputs to find where each erase block lies before it issues erase or program operations of its own.

Top module: `cfi_qry_engine`

## Requirements
- R1: After reset done_o, valid_o, fail_o, region_clamp_o, both bus strobes and every result output are zero.
- R2: An accepted start first issues bus write 0xF0 at command offset 0x00, then write 0x98 at command offset 0x55. After that come reads of offsets 0x10, 0x11, 0x12, then 0x13, 0x14, 0x1F, 0x23, 0x21, 0x25, 0x27, 0x2C, then four bytes per stored region in rising offset order starting at 0x2D.
- R3: With WIDE_DEV=1 every bus address equals the command offset shifted left by one.
- R4: If a signature byte differs from 0x51, 0x52 or 0x59 in turn, the engine stops after that read with done_o=1, fail_o=1, valid_o=0, vendor_o=0 and num_regions_o=0, and issues no further bus access.
- R5: vendor_o equals the byte at 0x14 times 256 plus the byte at 0x13.
- R6: wr_exp_o is the sum of the bytes at 0x1F and 0x23, er_exp_o is the sum of the bytes at 0x21 and 0x25, and size_o is 1 shifted left by the byte at 0x27.
- R7: For region r the block count is one plus the little-endian field at 0x2D+4r, and the block size is 256 times the little-endian field at 0x2F+4r, or 128 when that field is zero. Region r occupies bits [r*W +: W] of each flat region output.
- R8: Region 0 starts at offset 0. Each later region starts at the previous start plus its block size times its block count, modulo 2^OFF_W. Slots beyond the stored count read zero.
- R9: On success the exit commands depend on vendor_o. Code 2 gives write 0xF0 then write 0xFF at offset 0x00. Codes 1 and 3 give write 0xFF only. Any other code gives no write. Then done_o=1 and valid_o=1.
- R10: A reported region count above MAX_REGIONS is stored as MAX_REGIONS with region_clamp_o=1, and only that many descriptors are read. Otherwise region_clamp_o=0.
- R11: done_o and all result outputs hold until the next start. A start while the engine is busy has no effect on the bus sequence or the results.
- R12: A bus strobe stays asserted with a stable address until bus_ready_i is high at a clock edge. Write and read strobes are never both high, and the strobes are low while the engine is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted only when idle |
| bus_addr_o | output | ADDR_W | Bus byte address |
| bus_wdata_o | output | 8 | Bus write data |
| bus_wr_o | output | 1 | Write strobe |
| bus_rd_o | output | 1 | Read strobe |
| bus_rdata_i | input | 8 | Bus read data, valid when ready is high |
| bus_ready_i | input | 1 | Transfer completes at this edge |
| done_o | output | 1 | Query finished |
| valid_o | output | 1 | Device found and decoded |
| fail_o | output | 1 | Signature mismatch, device absent |
| region_clamp_o | output | 1 | Reported region count exceeded storage |
| vendor_o | output | 16 | Command-set code |
| wr_exp_o | output | 9 | Write timeout exponent |
| er_exp_o | output | 9 | Erase timeout exponent |
| size_o | output | SIZE_W | Device size in bytes |
| num_regions_o | output | CNT_W | Stored region count |
| region_start_o | output | MAX_REGIONS*OFF_W | Region start offsets |
| region_blocks_o | output | MAX_REGIONS*17 | Region block counts |
| region_bsize_o | output | MAX_REGIONS*24 | Region block sizes in bytes |

## Verification
The bench uses the default parameters: 16-bit device mode, eight region slots, a 24-bit bus address and 32-bit offsets and size. With these settings a reported count of nine exercises the clamp. The doubled command addresses show up on every transfer. A 0xFFFF size field with a single block pushes later start offsets past 24 bits. Bus latencies of zero to three wait cycles exercise the hold-until-ready handshake.

// File: rtl/cfi_qry_pkg.sv
package cfi_qry_pkg;
  localparam int BLK_W = 17;
  localparam int BSZ_W = 24;

  typedef enum logic [2:0] {
    PH_IDLE, PH_RESET, PH_ENTER, PH_SIG, PH_HDR, PH_REG, PH_EXIT0, PH_EXIT1
  } phase_e;

  localparam logic [7:0] CMD_RESET = 8'hF0;
  localparam logic [7:0] CMD_QUERY = 8'h98;
  localparam logic [7:0] CMD_ARRAY = 8'hFF;
  localparam logic [7:0] OFF_QUERY = 8'h55;
  localparam logic [7:0] OFF_SIG   = 8'h10;
  localparam logic [7:0] OFF_RGN   = 8'h2D;

  localparam logic [15:0] CS_TOGGLE = 16'd2;
  localparam logic [15:0] CS_STAT_A = 16'd1;
  localparam logic [15:0] CS_STAT_B = 16'd3;

  function automatic logic [7:0] sig_byte(input logic [2:0] i);
    case (i)
      3'd0:    sig_byte = 8'h51;
      3'd1:    sig_byte = 8'h52;
      default: sig_byte = 8'h59;
    endcase
  endfunction

  function automatic logic [7:0] hdr_off(input logic [2:0] i);
    case (i)
      3'd0: hdr_off = 8'h13;
      3'd1: hdr_off = 8'h14;
      3'd2: hdr_off = 8'h1F;
      3'd3: hdr_off = 8'h23;
      3'd4: hdr_off = 8'h21;
      3'd5: hdr_off = 8'h25;
      3'd6: hdr_off = 8'h27;
      default: hdr_off = 8'h2C;
    endcase
  endfunction
endpackage

// File: rtl/cfi_qry_bus.sv
module cfi_qry_bus #(
  parameter int ADDR_W   = 24,
  parameter bit WIDE_DEV = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [7:0]        off_i,
  input  logic [7:0]        wdata_i,
  output logic              ack_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [7:0]        wdata_o,
  output logic              wr_o,
  output logic              rd_o,
  input  logic              ready_i
);
  localparam int SH = WIDE_DEV ? 1 : 0;

  logic              busy_q, we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        wdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (req_i && !busy_q) begin
      busy_q  <= 1'b1;
      we_q    <= we_i;
      addr_q  <= ADDR_W'(off_i) << SH;
      wdata_q <= wdata_i;
    end else if (busy_q && ready_i) begin
      busy_q <= 1'b0;
    end
  end

  assign ack_o   = busy_q & ready_i;
  assign addr_o  = addr_q;
  assign wdata_o = wdata_q;
  assign wr_o    = busy_q & we_q;
  assign rd_o    = busy_q & ~we_q;

  a_r12_strobe_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_o && rd_o));
  a_r12_hold_until_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_o || rd_o) && !ready_i |=> (wr_o || rd_o) && $stable(addr_o) && $stable(wdata_o));
endmodule

// File: rtl/cfi_qry_region_dec.sv
module cfi_qry_region_dec
  import cfi_qry_pkg::*;
#(
  parameter int OFF_W = 32
) (
  input  logic [15:0]      cnt_fld_i,
  input  logic [15:0]      sz_fld_i,
  input  logic [OFF_W-1:0] base_i,
  output logic [BLK_W-1:0] blocks_o,
  output logic [BSZ_W-1:0] bsize_o,
  output logic [OFF_W-1:0] next_o
);
  assign blocks_o = BLK_W'(cnt_fld_i) + BLK_W'(1);
  assign bsize_o  = (sz_fld_i == 16'd0) ? BSZ_W'(128) : {sz_fld_i, 8'h00};
  assign next_o   = base_i + OFF_W'(OFF_W'(bsize_o) * OFF_W'(blocks_o));
endmodule

// File: rtl/cfi_qry_engine.sv
module cfi_qry_engine
  import cfi_qry_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter bit WIDE_DEV    = 1'b1,
  parameter int MAX_REGIONS = 8,
  parameter int OFF_W       = 32,
  parameter int SIZE_W      = 32,
  localparam int CNT_W      = $clog2(MAX_REGIONS + 1)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         start_i,
  output logic [ADDR_W-1:0]            bus_addr_o,
  output logic [7:0]                   bus_wdata_o,
  output logic                         bus_wr_o,
  output logic                         bus_rd_o,
  input  logic [7:0]                   bus_rdata_i,
  input  logic                         bus_ready_i,
  output logic                         done_o,
  output logic                         valid_o,
  output logic                         fail_o,
  output logic                         region_clamp_o,
  output logic [15:0]                  vendor_o,
  output logic [8:0]                   wr_exp_o,
  output logic [8:0]                   er_exp_o,
  output logic [SIZE_W-1:0]            size_o,
  output logic [CNT_W-1:0]             num_regions_o,
  output logic [MAX_REGIONS*OFF_W-1:0] region_start_o,
  output logic [MAX_REGIONS*BLK_W-1:0] region_blocks_o,
  output logic [MAX_REGIONS*BSZ_W-1:0] region_bsize_o
);
  phase_e            ph_q, exit_ph;
  logic              wait_q;
  logic [2:0]        idx_q;
  logic [CNT_W-1:0]  ridx_q, num_q, num_new;
  logic [7:0]        b0_q, b1_q, b2_q;
  logic              done_q, valid_q, fail_q, clamp_q, raw_gt;
  logic [15:0]       vendor_q;
  logic [8:0]        wexp_q, eexp_q;
  logic [SIZE_W-1:0] size_q;
  logic [OFF_W-1:0]  acc_q, dec_next;
  logic [BLK_W-1:0]  dec_blocks;
  logic [BSZ_W-1:0]  dec_bsize;

  logic       req, ack, op_we, clr, commit;
  logic [7:0] op_off, op_wdata;

  assign req    = (ph_q != PH_IDLE) && !wait_q;
  assign clr    = start_i && (ph_q == PH_IDLE);
  assign commit = ack && (ph_q == PH_REG) && (idx_q == 3'd3);

  always_comb begin
    op_we    = 1'b0;
    op_off   = 8'h00;
    op_wdata = 8'h00;
    case (ph_q)
      PH_RESET: begin op_we = 1'b1; op_wdata = CMD_RESET; end
      PH_ENTER: begin op_we = 1'b1; op_off = OFF_QUERY; op_wdata = CMD_QUERY; end
      PH_SIG:   op_off = OFF_SIG + 8'(idx_q);
      PH_HDR:   op_off = hdr_off(idx_q);
      PH_REG:   op_off = OFF_RGN + (8'(ridx_q) << 2) + 8'(idx_q);
      PH_EXIT0: begin op_we = 1'b1; op_wdata = CMD_RESET; end
      PH_EXIT1: begin op_we = 1'b1; op_wdata = CMD_ARRAY; end
      default:  ;
    endcase
  end

  always_comb begin
    case (vendor_q)
      CS_TOGGLE:            exit_ph = PH_EXIT0;
      CS_STAT_A, CS_STAT_B: exit_ph = PH_EXIT1;
      default:              exit_ph = PH_IDLE;
    endcase
  end

  assign raw_gt  = int'(bus_rdata_i) > MAX_REGIONS;
  assign num_new = raw_gt ? CNT_W'(MAX_REGIONS) : CNT_W'(bus_rdata_i);

  cfi_qry_bus #(.ADDR_W(ADDR_W), .WIDE_DEV(WIDE_DEV)) u_bus (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req),
    .we_i    (op_we),
    .off_i   (op_off),
    .wdata_i (op_wdata),
    .ack_o   (ack),
    .addr_o  (bus_addr_o),
    .wdata_o (bus_wdata_o),
    .wr_o    (bus_wr_o),
    .rd_o    (bus_rd_o),
    .ready_i (bus_ready_i)
  );

  cfi_qry_region_dec #(.OFF_W(OFF_W)) u_dec (
    .cnt_fld_i ({b1_q, b0_q}),
    .sz_fld_i  ({bus_rdata_i, b2_q}),
    .base_i    (acc_q),
    .blocks_o  (dec_blocks),
    .bsize_o   (dec_bsize),
    .next_o    (dec_next)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q     <= PH_IDLE;
      wait_q   <= 1'b0;
      idx_q    <= '0;
      ridx_q   <= '0;
      num_q    <= '0;
      b0_q     <= '0;
      b1_q     <= '0;
      b2_q     <= '0;
      done_q   <= 1'b0;
      valid_q  <= 1'b0;
      fail_q   <= 1'b0;
      clamp_q  <= 1'b0;
      vendor_q <= '0;
      wexp_q   <= '0;
      eexp_q   <= '0;
      size_q   <= '0;
      acc_q    <= '0;
    end else if (clr) begin
      ph_q     <= PH_RESET;
      wait_q   <= 1'b0;
      idx_q    <= '0;
      ridx_q   <= '0;
      num_q    <= '0;
      done_q   <= 1'b0;
      valid_q  <= 1'b0;
      fail_q   <= 1'b0;
      clamp_q  <= 1'b0;
      vendor_q <= '0;
      wexp_q   <= '0;
      eexp_q   <= '0;
      size_q   <= '0;
      acc_q    <= '0;
    end else if (ack) begin
      wait_q <= 1'b0;
      case (ph_q)
        PH_RESET: ph_q <= PH_ENTER;
        PH_ENTER: begin ph_q <= PH_SIG; idx_q <= '0; end
        PH_SIG: begin
          if (bus_rdata_i != sig_byte(idx_q)) begin
            ph_q   <= PH_IDLE;
            done_q <= 1'b1;
            fail_q <= 1'b1;
          end else if (idx_q == 3'd2) begin
            ph_q  <= PH_HDR;
            idx_q <= '0;
          end else begin
            idx_q <= idx_q + 3'd1;
          end
        end
        PH_HDR: begin
          idx_q <= idx_q + 3'd1;
          case (idx_q)
            3'd0: vendor_q[7:0]  <= bus_rdata_i;
            3'd1: vendor_q[15:8] <= bus_rdata_i;
            3'd2: wexp_q <= {1'b0, bus_rdata_i};
            3'd3: wexp_q <= wexp_q + {1'b0, bus_rdata_i};
            3'd4: eexp_q <= {1'b0, bus_rdata_i};
            3'd5: eexp_q <= eexp_q + {1'b0, bus_rdata_i};
            3'd6: size_q <= SIZE_W'(1) << bus_rdata_i;
            default: begin
              num_q   <= num_new;
              clamp_q <= raw_gt;
              idx_q   <= '0;
              ridx_q  <= '0;
              if (num_new != '0) begin
                ph_q <= PH_REG;
              end else if (exit_ph == PH_IDLE) begin
                ph_q    <= PH_IDLE;
                done_q  <= 1'b1;
                valid_q <= 1'b1;
              end else begin
                ph_q <= exit_ph;
              end
            end
          endcase
        end
        PH_REG: begin
          case (idx_q)
            3'd0: b0_q <= bus_rdata_i;
            3'd1: b1_q <= bus_rdata_i;
            3'd2: b2_q <= bus_rdata_i;
            default: ;
          endcase
          if (idx_q != 3'd3) begin
            idx_q <= idx_q + 3'd1;
          end else begin
            idx_q <= '0;
            acc_q <= dec_next;
            if (ridx_q + CNT_W'(1) == num_q) begin
              if (exit_ph == PH_IDLE) begin
                ph_q    <= PH_IDLE;
                done_q  <= 1'b1;
                valid_q <= 1'b1;
              end else begin
                ph_q <= exit_ph;
              end
            end else begin
              ridx_q <= ridx_q + CNT_W'(1);
            end
          end
        end
        PH_EXIT0: ph_q <= PH_EXIT1;
        PH_EXIT1: begin
          ph_q    <= PH_IDLE;
          done_q  <= 1'b1;
          valid_q <= 1'b1;
        end
        default: ph_q <= PH_IDLE;
      endcase
    end else if (req) begin
      wait_q <= 1'b1;
    end
  end

  for (genvar g = 0; g < MAX_REGIONS; g++) begin : g_rgn
    logic [OFF_W-1:0] st_q;
    logic [BLK_W-1:0] bk_q;
    logic [BSZ_W-1:0] bs_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        st_q <= '0;
        bk_q <= '0;
        bs_q <= '0;
      end else if (clr) begin
        st_q <= '0;
        bk_q <= '0;
        bs_q <= '0;
      end else if (commit && ridx_q == CNT_W'(g)) begin
        st_q <= acc_q;
        bk_q <= dec_blocks;
        bs_q <= dec_bsize;
      end
    end
    assign region_start_o[g*OFF_W +: OFF_W]  = st_q;
    assign region_blocks_o[g*BLK_W +: BLK_W] = bk_q;
    assign region_bsize_o[g*BSZ_W +: BSZ_W]  = bs_q;
  end

  assign done_o         = done_q;
  assign valid_o        = valid_q;
  assign fail_o         = fail_q;
  assign region_clamp_o = clamp_q;
  assign vendor_o       = vendor_q;
  assign wr_exp_o       = wexp_q;
  assign er_exp_o       = eexp_q;
  assign size_o         = size_q;
  assign num_regions_o  = num_q;

  a_r4_flag_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_o && fail_o) && ((valid_o || fail_o) == done_o));
  a_r10_count_max: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(num_regions_o) <= MAX_REGIONS);
  a_r11_done_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !start_i |=> done_o && $stable(vendor_o) && $stable(region_start_o));
  a_r12_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == PH_IDLE) |-> !(bus_wr_o || bus_rd_o));
endmodule

// File: tb/cfi_qry_engine_tb.sv
module cfi_qry_engine_tb;
  localparam int MAXR = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [23:0] bus_addr;
  logic [7:0]  bus_wdata, bus_rdata;
  logic        bus_wr, bus_rd;
  logic        bus_ready = 1'b0;
  logic        done, valid, fail, clamp;
  logic [15:0] vendor;
  logic [8:0]  wexp, eexp;
  logic [31:0] size;
  logic [3:0]  nreg;
  logic [MAXR*32-1:0] rstart;
  logic [MAXR*17-1:0] rblk;
  logic [MAXR*24-1:0] rbsz;

  always #5 clk = ~clk;

  cfi_qry_engine u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .bus_addr_o(bus_addr), .bus_wdata_o(bus_wdata), .bus_wr_o(bus_wr), .bus_rd_o(bus_rd),
    .bus_rdata_i(bus_rdata), .bus_ready_i(bus_ready),
    .done_o(done), .valid_o(valid), .fail_o(fail), .region_clamp_o(clamp),
    .vendor_o(vendor), .wr_exp_o(wexp), .er_exp_o(eexp), .size_o(size),
    .num_regions_o(nreg), .region_start_o(rstart), .region_blocks_o(rblk),
    .region_bsize_o(rbsz)
  );

  // device model indexed by command offset (bus address >> 1, R3)
  logic [7:0] mem [0:255];
  assign bus_rdata = mem[bus_addr[8:1]];

  int ntests = 0, nfail = 0;
  int lat = 0, wcnt = 0;
  int cyc = 0;

  bit exp_we[$];
  int exp_addr[$];
  int exp_data[$];

  int cfg_vendor, cfg_n;
  int cfg_cnt [0:MAXR];
  int cfg_sz  [0:MAXR];

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    ntests++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s act=0x%0h exp=0x%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (bus_wr || bus_rd) begin
      if (wcnt >= lat) bus_ready = 1'b1;
      else begin bus_ready = 1'b0; wcnt++; end
    end else begin
      bus_ready = 1'b0;
      wcnt = 0;
    end
  end

  // monitor: pop and compare each completed bus transfer (R2 R3 R9 R12)
  always @(posedge clk) begin
    if (rst_n && (bus_wr || bus_rd) && bus_ready) begin
      ntests++;
      if (exp_we.size() == 0) begin
        nfail++;
        $display("FAIL R12 unexpected txn act=0x%0h exp=none", bus_addr);
      end else begin
        bit w; int a; int d;
        w = exp_we.pop_front(); a = exp_addr.pop_front(); d = exp_data.pop_front();
        if (bus_wr !== w || int'(bus_addr) != a || (w && int'(bus_wdata) != d)) begin
          nfail++;
          $display("FAIL R2 txn act=we%0b@0x%0h:0x%0h exp=we%0b@0x%0h:0x%0h",
                   bus_wr, bus_addr, bus_wdata, w, a, d);
        end
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        nfail++;
        $display("FAIL watchdog act=%0d exp=<150000", cyc);
        $display("[TB] %0d tests run, %0d failed", ntests, nfail);
        $finish;
      end
    end
  end

  task automatic push(input bit w, input int off, input int d);
    exp_we.push_back(w);
    exp_addr.push_back(off << 1);   // R3
    exp_data.push_back(d);
  endtask

  task automatic load_dev(input int vend, input int n, input int w1, input int w2,
                          input int e1, input int e2, input int sz);
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    mem[8'h10] = 8'h51; mem[8'h11] = 8'h52; mem[8'h12] = 8'h59;
    mem[8'h13] = 8'(vend); mem[8'h14] = 8'(vend >> 8);
    mem[8'h1F] = 8'(w1); mem[8'h23] = 8'(w2);
    mem[8'h21] = 8'(e1); mem[8'h25] = 8'(e2);
    mem[8'h27] = 8'(sz); mem[8'h2C] = 8'(n);
    cfg_vendor = vend; cfg_n = n;
    for (int r = 0; r <= MAXR; r++) begin
      mem[8'h2D + 4*r]     = 8'(cfg_cnt[r]);
      mem[8'h2D + 4*r + 1] = 8'(cfg_cnt[r] >> 8);
      mem[8'h2D + 4*r + 2] = 8'(cfg_sz[r]);
      mem[8'h2D + 4*r + 3] = 8'(cfg_sz[r] >> 8);
    end
  endtask

  // build the expected bus stream (R2, R9, R10); bad_sig = index of bad byte or -1
  task automatic push_stream(input int bad_sig);
    int hdr [8] = '{8'h13, 8'h14, 8'h1F, 8'h23, 8'h21, 8'h25, 8'h27, 8'h2C};
    int n;
    push(1, 8'h00, 8'hF0);
    push(1, 8'h55, 8'h98);
    for (int i = 0; i < 3; i++) begin
      push(0, 8'h10 + i, 0);
      if (i == bad_sig) return;
    end
    for (int i = 0; i < 8; i++) push(0, hdr[i], 0);
    n = (cfg_n > MAXR) ? MAXR : cfg_n;
    for (int r = 0; r < n; r++)
      for (int b = 0; b < 4; b++) push(0, 8'h2D + 4*r + b, 0);
    if (cfg_vendor == 2) begin push(1, 0, 8'hF0); push(1, 0, 8'hFF); end
    else if (cfg_vendor == 1 || cfg_vendor == 3) push(1, 0, 8'hFF);
  endtask

  task automatic pulse_start;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_done;
    int t = 0;
    while (!done && t < 20000) begin @(negedge clk); t++; end
  endtask

  task automatic check_geom(input string tag);
    int n;
    logic [31:0] acc, st;
    longint bk, bs;
    n = (cfg_n > MAXR) ? MAXR : cfg_n;
    acc = 0;
    chk(done && valid && !fail, {tag, " R9 done/valid"}, {done, valid, fail}, 3'b110);
    chk(vendor == 16'(cfg_vendor), {tag, " R5 vendor"}, vendor, cfg_vendor);
    chk(wexp == 9'(mem[8'h1F] + mem[8'h23]), {tag, " R6 wexp"}, wexp, mem[8'h1F] + mem[8'h23]);
    chk(eexp == 9'(mem[8'h21] + mem[8'h25]), {tag, " R6 eexp"}, eexp, mem[8'h21] + mem[8'h25]);
    chk(size == (32'd1 << mem[8'h27]), {tag, " R6 size"}, size, 32'd1 << mem[8'h27]);
    chk(int'(nreg) == n, {tag, " R10 count"}, nreg, n);
    chk(clamp == (cfg_n > MAXR), {tag, " R10 flag"}, clamp, cfg_n > MAXR);
    for (int r = 0; r < MAXR; r++) begin
      if (r < n) begin
        bk = cfg_cnt[r] + 1;
        bs = (cfg_sz[r] == 0) ? 128 : cfg_sz[r] * 256;
        st = acc;
        acc = acc + 32'(bk * bs);
      end else begin
        bk = 0; bs = 0; st = 0;
      end
      chk(rblk[r*17 +: 17] == 17'(bk), $sformatf("%s R7 blocks[%0d]", tag, r), rblk[r*17 +: 17], bk);
      chk(rbsz[r*24 +: 24] == 24'(bs), $sformatf("%s R7 bsize[%0d]", tag, r), rbsz[r*24 +: 24], bs);
      chk(rstart[r*32 +: 32] == st, $sformatf("%s R8 start[%0d]", tag, r), rstart[r*32 +: 32], st);
    end
    chk(exp_we.size() == 0, {tag, " R2 stream consumed"}, exp_we.size(), 0);
  endtask

  initial begin
    for (int r = 0; r <= MAXR; r++) begin cfg_cnt[r] = 0; cfg_sz[r] = 0; end
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!done && !valid && !fail && !clamp, "R1 flags", {done, valid, fail, clamp}, 0);
    chk(!bus_wr && !bus_rd, "R1 strobes", {bus_wr, bus_rd}, 0);
    chk(vendor == 0 && size == 0 && nreg == 0 && rstart == 0 && rblk == 0 && rbsz == 0,
        "R1 results", vendor, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // toggle-bit set, two regions, zero latency (R7 zero size field, R9 two exit writes)
    cfg_cnt[0] = 7;     cfg_sz[0] = 16'h0040;
    cfg_cnt[1] = 16'hFE; cfg_sz[1] = 0;
    load_dev(2, 2, 4, 5, 10, 6, 8'h15);
    lat = 0;
    push_stream(-1);
    pulse_start();
    wait_done();
    check_geom("t_vendor2");
    // R11 outputs hold while idle
    repeat (10) @(negedge clk);
    chk(done && vendor == 16'd2 && rstart[32 +: 32] == 32'h20000, "R11 hold", rstart[32 +: 32], 32'h20000);

    // status set A, three regions incl. widest size, latency 3, start while busy (R11)
    cfg_cnt[0] = 0; cfg_sz[0] = 16'hFFFF;
    cfg_cnt[1] = 1; cfg_sz[1] = 1;
    cfg_cnt[2] = 3; cfg_sz[2] = 0;
    load_dev(1, 3, 1, 2, 3, 4, 8'h18);
    lat = 3;
    push_stream(-1);
    pulse_start();
    repeat (40) @(negedge clk);
    pulse_start();   // R11: busy, must be ignored
    wait_done();
    check_geom("t_vendor1");
    chk(rstart[64 +: 32] == 32'h0100_0100, "R8 offset past 24 bits", rstart[64 +: 32], 32'h0100_0100);

    // unknown command set, zero regions: no exit writes (R9)
    load_dev(5, 0, 0, 0, 0, 0, 8'h10);
    lat = 1;
    push_stream(-1);
    pulse_start();
    wait_done();
    check_geom("t_vendor5");
    repeat (10) @(negedge clk);
    chk(exp_we.size() == 0, "R9 no exit write", exp_we.size(), 0);

    // status set B, nine reported regions -> clamp (R10)
    for (int r = 0; r <= MAXR; r++) begin cfg_cnt[r] = r + 1; cfg_sz[r] = r; end
    load_dev(3, 9, 7, 7, 9, 9, 8'h1A);
    lat = 0;
    push_stream(-1);
    pulse_start();
    wait_done();
    check_geom("t_clamp");

    // bad signature third byte (R4)
    load_dev(2, 2, 1, 1, 1, 1, 8'h10);
    mem[8'h12] = 8'h5A;
    lat = 2;
    push_stream(2);
    pulse_start();
    wait_done();
    chk(done && fail && !valid, "R4 fail flags", {done, valid, fail}, 3'b101);
    chk(vendor == 0 && nreg == 0, "R4 cleared results", vendor, 0);
    repeat (20) @(negedge clk);
    chk(exp_we.size() == 0 && !bus_wr && !bus_rd, "R4 no further access", exp_we.size(), 0);
    chk(done && fail, "R11 fail held", {done, fail}, 2'b11);

    $display("[TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end
endmodule